// File: doc/BRIEF.md
# Page Write Staging Buffer

This block gathers the bytes of one page write between a serial byte receiver and a byte-wide storage array. A load opens with a starting word address. Completed bytes then arrive one strobe at a time. The load closes with a commit or an abort.

The buffer keeps a copy of each byte it receives and a per-byte valid flag. On commit it drives the array's write port with only the bytes that were loaded. This happens either as a back-to-back burst or, in a legacy mode, as one byte per programming cycle. A busy output stays high for the programming time.

The receiver tells the buffer when a byte is only partly shifted in. A commit that lands at that moment either drops the partial byte or, in strict mode, cancels the whole load.

Top module: `pgwr_buffer`

## Requirements
- R1: After reset, `busy` and `mem_we` are low.
- R2: The word address splits into a page number (upper ADDR_W-log2(PAGE_BYTES) bits) and a byte offset (lower log2(PAGE_BYTES) bits). Every write for one commit keeps the page of the load's start address, and each byte lands at {page, offset}.
- R3: Each stored byte advances the offset by one, modulo PAGE_BYTES, and never carries into the page number. A byte stored at an offset that already holds one replaces it, so the last value loaded there is the one written.
- R4: A commit writes exactly the offsets loaded since the load opened, each once, in ascending offset order. All other array locations keep their contents.
- R5: When STRICT_ABORT is 0, a commit with `byte_partial` high writes the completed bytes. The partial byte is not written.
- R6: When STRICT_ABORT is 1, a commit with `byte_partial` high cancels the load. No write occurs, `busy` stays low and the load is closed.
- R7: When SERIAL_PROG is 0, the writes occupy consecutive cycles, starting in the first cycle after the commit edge. `busy` is high for exactly BUSY_CYCLES cycles, which assumes BUSY_CYCLES >= PAGE_BYTES.
- R8: When SERIAL_PROG is 1, each loaded byte gets its own programming slot of BUSY_CYCLES cycles, with its write in the slot's first cycle. `busy` lasts n*BUSY_CYCLES cycles for n loaded bytes.
- R9: An abort, or a commit with no byte loaded, causes no write and leaves `busy` low.
- R10: While `busy` is high, `ld_start`, `byte_stb`, `ld_commit` and `ld_abort` have no effect. They neither open a load nor store a byte.
- R11: A byte strobe with no open load is ignored. A new `ld_start` clears all valid flags, including during an open load. A commit or abort closes the load.
- R12: `mem_we` is high only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_start | input | 1 | Open a new load at `ld_addr` |
| ld_addr | input | ADDR_W | Starting word address of the load |
| byte_stb | input | 1 | One completed byte is on `byte_data` |
| byte_data | input | DATA_W | Received byte |
| byte_partial | input | 1 | Receiver holds an incomplete byte |
| ld_commit | input | 1 | Close the load and program it |
| ld_abort | input | 1 | Close the load without programming |
| busy | output | 1 | Programming in progress |
| mem_we | output | 1 | Array write enable, one byte per cycle |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | DATA_W | Array write data |

## Verification
The assertions watch properties that hold every cycle:
- writes happen only under busy;
- busy starts only from a commit;
- consecutive writes stay in one page and climb in offset;
- the first burst write follows the commit at once;
- legacy-mode writes never fall on adjacent cycles;
- a strict-mode mid-byte commit never raises busy.

Only the bench's scenarios can show the rest. These are the array contents after each commit, including untouched neighbours and wrapped overwrites. They also include the exact busy length per mode and the effect of stimulus that the buffer should have ignored. The bench sweeps every start offset and several load lengths, on a 16-byte burst configuration and an 8-byte strict legacy configuration, both driven with the same stimulus.

// File: rtl/pgwr_pkg.sv
// Shared types for the page write staging buffer.
package pgwr_pkg;
    typedef enum logic {
        PG_IDLE = 1'b0,
        PG_PROG = 1'b1
    } pg_state_e;
endpackage

// File: rtl/pgwr_timer.sv
// Programming-time counter.
// Counts up from zero while enabled and saturates at LIMIT-1.
// Assumes LIMIT >= 1.
module pgwr_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic first,
    output logic done
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] cnt_q;

    assign first = (cnt_q == '0);
    assign done  = (cnt_q == CW'(LIMIT - 1));

    // Restart on clear, otherwise step until the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (en && !done)
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/pgwr_load.sv
// Page load store.
// Holds one page of bytes, one valid flag per byte, the page number
// and the running offset.
// Assumes the caller has already qualified its strobes:
//   start wins over close, close wins over byte_stb.
// PAGE_BYTES must be a power of two, so the offset wraps naturally.
module pgwr_load #(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 16,
    localparam int OFF_W     = $clog2(PAGE_BYTES),
    localparam int PAGE_W    = ADDR_W - OFF_W
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 start,
    input  logic [ADDR_W-1:0]                    start_addr,
    input  logic                                 byte_stb,
    input  logic [DATA_W-1:0]                    byte_data,
    input  logic                                 close,
    output logic                                 load_open,
    output logic [PAGE_W-1:0]                    page,
    output logic [PAGE_BYTES-1:0]                valid,
    output logic [PAGE_BYTES-1:0][DATA_W-1:0]    slot_data
);
    logic [OFF_W-1:0] off_q;

    // Open or close the load and latch the page and starting offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_open <= 1'b0;
            page      <= '0;
            off_q     <= '0;
        end else if (start) begin
            load_open <= 1'b1;
            page      <= start_addr[ADDR_W-1:OFF_W];
            off_q     <= start_addr[OFF_W-1:0];
        end else if (close) begin
            load_open <= 1'b0;
        end else if (byte_stb) begin
            off_q <= off_q + 1'b1;
        end
    end

    for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_slot
        // Per-byte valid flag: cleared by a new load or a close, set on store.
        always_ff @(posedge clk) begin
            if (!rst_n)
                valid[i] <= 1'b0;
            else if (start || close)
                valid[i] <= 1'b0;
            else if (byte_stb && off_q == OFF_W'(i))
                valid[i] <= 1'b1;
        end

        // Per-byte data holder: the latest byte stored at this offset wins.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_data[i] <= '0;
            else if (!start && !close && byte_stb && off_q == OFF_W'(i))
                slot_data[i] <= byte_data;
        end
    end
endmodule

// File: rtl/pgwr_engine.sv
// Program sequencer.
// On launch it snapshots the valid flags into a pending mask.
// It then issues one write per pending offset, lowest offset first.
//   Burst mode: writes go out on consecutive cycles, and busy holds
//     for BUSY_CYCLES cycles (assumes BUSY_CYCLES >= PAGE_BYTES).
//   Serial mode: each byte has its own slot of BUSY_CYCLES cycles.
// Assumes launch is only raised while idle.
module pgwr_engine
    import pgwr_pkg::*;
#(
    parameter int PAGE_BYTES  = 16,
    parameter int BUSY_CYCLES = 20,
    parameter bit SERIAL_PROG = 1'b0,
    localparam int OFF_W      = $clog2(PAGE_BYTES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  launch,
    input  logic [PAGE_BYTES-1:0] load_valid,
    output logic                  busy,
    output logic                  wr_en,
    output logic [OFF_W-1:0]      wr_off
);
    localparam logic [PAGE_BYTES-1:0] ONE = PAGE_BYTES'(1);

    pg_state_e             st_q;
    logic [PAGE_BYTES-1:0] pend_q;
    logic [PAGE_BYTES-1:0] pend_nx;
    logic                  hit;
    logic                  slot_first;
    logic                  slot_done;
    logic                  slot_ok;
    logic                  tmr_clr;

    // Find the lowest pending offset.
    always_comb begin
        hit    = 1'b0;
        wr_off = '0;
        for (int i = 0; i < PAGE_BYTES; i++) begin
            if (pend_q[i] && !hit) begin
                hit    = 1'b1;
                wr_off = OFF_W'(i);
            end
        end
    end

    // Serial mode writes only in a slot's first cycle; burst mode writes every cycle.
    assign slot_ok = SERIAL_PROG ? slot_first : 1'b1;
    assign busy    = (st_q == PG_PROG);
    assign wr_en   = busy && hit && slot_ok;
    assign pend_nx = pend_q & ~(wr_en ? (ONE << wr_off) : '0);
    assign tmr_clr = launch || (SERIAL_PROG && busy && slot_done && pend_nx != '0);

    pgwr_timer #(
        .LIMIT (BUSY_CYCLES)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .en    (busy),
        .first (slot_first),
        .done  (slot_done)
    );

    // Enter programming on launch; leave when time is up and nothing is pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= PG_IDLE;
            pend_q <= '0;
        end else if (launch) begin
            st_q   <= PG_PROG;
            pend_q <= load_valid;
        end else if (busy) begin
            pend_q <= pend_nx;
            if (slot_done && pend_nx == '0)
                st_q <= PG_IDLE;
        end
    end
endmodule

// File: rtl/pgwr_buffer.sv
// Page write staging buffer, top level.
// Qualifies the load-side strobes and gates them all while busy.
//   ld_start takes priority over commit and abort.
//   Commit takes priority over abort.
//   A byte strobe that coincides with any of these is dropped.
// Builds the array address from the held page and the sequencer's offset.
// Assumes PAGE_BYTES is 8 or 16.
module pgwr_buffer #(
    parameter int ADDR_W       = 8,
    parameter int DATA_W       = 8,
    parameter int PAGE_BYTES   = 16,
    parameter int BUSY_CYCLES  = 20,
    parameter bit SERIAL_PROG  = 1'b0,
    parameter bit STRICT_ABORT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_start,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic              byte_stb,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              byte_partial,
    input  logic              ld_commit,
    input  logic              ld_abort,
    output logic              busy,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);
    localparam int OFF_W  = $clog2(PAGE_BYTES);
    localparam int PAGE_W = ADDR_W - OFF_W;

    logic                              load_open;
    logic [PAGE_W-1:0]                 page;
    logic [PAGE_BYTES-1:0]             valid;
    logic [PAGE_BYTES-1:0][DATA_W-1:0] slot_data;
    logic [OFF_W-1:0]                  wr_off;
    logic cmd_start, cmd_commit, cmd_abort, cmd_byte;
    logic cancel, launch, close;

    // Qualify the load-side commands; nothing is accepted while busy.
    assign cmd_start  = ld_start && !busy;
    assign cmd_commit = ld_commit && !busy && load_open && !ld_start;
    assign cmd_abort  = ld_abort && !busy && load_open && !ld_start && !ld_commit;
    assign cmd_byte   = byte_stb && !busy && load_open && !ld_start && !ld_commit && !ld_abort;
    assign cancel     = cmd_commit && STRICT_ABORT && byte_partial;
    assign launch     = cmd_commit && !cancel && (|valid);
    assign close      = cmd_commit || cmd_abort;

    pgwr_load #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_load (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (cmd_start),
        .start_addr (ld_addr),
        .byte_stb   (cmd_byte),
        .byte_data  (byte_data),
        .close      (close),
        .load_open  (load_open),
        .page       (page),
        .valid      (valid),
        .slot_data  (slot_data)
    );

    pgwr_engine #(
        .PAGE_BYTES  (PAGE_BYTES),
        .BUSY_CYCLES (BUSY_CYCLES),
        .SERIAL_PROG (SERIAL_PROG)
    ) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .load_valid (valid),
        .busy       (busy),
        .wr_en      (mem_we),
        .wr_off     (wr_off)
    );

    // Array write port: held page number with the current offset.
    assign mem_addr  = {page, wr_off};
    assign mem_wdata = slot_data[wr_off];
endmodule

// File: rtl/pgwr_buffer_chk.sv
// Cycle-level properties of the page write staging buffer.
// Attached to every instance of pgwr_buffer by the bind below.
module pgwr_buffer_chk #(
    parameter int ADDR_W       = 8,
    parameter int PAGE_BYTES   = 16,
    parameter int BUSY_CYCLES  = 20,
    parameter bit SERIAL_PROG  = 1'b0,
    parameter bit STRICT_ABORT = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ld_start,
    input logic              byte_partial,
    input logic              ld_commit,
    input logic              busy,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr
);
    localparam int OFF_W = $clog2(PAGE_BYTES);

    // R12: no array write outside a busy period.
    a_r12_we_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    // R10: busy can only begin on the edge that sampled a commit.
    a_r10_busy_from_commit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(ld_commit));

    // R2: back-to-back writes stay inside one page.
    a_r2_same_page: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we) && $past(busy))
        |-> mem_addr[ADDR_W-1:OFF_W] == $past(mem_addr[ADDR_W-1:OFF_W]));

    // R4: back-to-back writes climb in offset.
    a_r4_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we) && $past(busy))
        |-> mem_addr[OFF_W-1:0] > $past(mem_addr[OFF_W-1:0]));

    if (!SERIAL_PROG) begin : g_burst
        // R7: the burst starts in the first busy cycle.
        a_r7_first_write: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(busy) |-> mem_we);
    end

    if (SERIAL_PROG && BUSY_CYCLES > 1) begin : g_serial
        // R8: one write per slot, so never two in adjacent cycles.
        a_r8_spaced: assert property (@(posedge clk) disable iff (!rst_n)
            mem_we |=> !mem_we);
    end

    if (STRICT_ABORT) begin : g_strict
        // R6: a mid-byte commit in strict mode never starts programming.
        a_r6_strict_cancel: assert property (@(posedge clk) disable iff (!rst_n)
            (!busy && ld_commit && byte_partial && !ld_start) |=> !busy);
    end
endmodule

bind pgwr_buffer pgwr_buffer_chk #(
    .ADDR_W       (ADDR_W),
    .PAGE_BYTES   (PAGE_BYTES),
    .BUSY_CYCLES  (BUSY_CYCLES),
    .SERIAL_PROG  (SERIAL_PROG),
    .STRICT_ABORT (STRICT_ABORT)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ld_start     (ld_start),
    .byte_partial (byte_partial),
    .ld_commit    (ld_commit),
    .busy         (busy),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr)
);

// File: tb/pgwr_buffer_bench.sv
// Drives two configurations with the same stimulus:
//   instance 0: 16-byte page, burst programming, lenient.
//   instance 1: 8-byte page, serial programming, strict.
module pgwr_buffer_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ld_start = 1'b0, byte_stb = 1'b0, byte_partial = 1'b0;
    logic ld_commit = 1'b0, ld_abort = 1'b0;
    logic [7:0] ld_addr = '0, byte_data = '0;

    logic busy_a, we_a, busy_b, we_b;
    logic [7:0] addr_a, wd_a, addr_b, wd_b;

    always #5 clk = ~clk;

    pgwr_buffer #(
        .PAGE_BYTES(16), .BUSY_CYCLES(20), .SERIAL_PROG(1'b0), .STRICT_ABORT(1'b0)
    ) u_pgwr_buffer (
        .clk(clk), .rst_n(rst_n), .ld_start(ld_start), .ld_addr(ld_addr),
        .byte_stb(byte_stb), .byte_data(byte_data), .byte_partial(byte_partial),
        .ld_commit(ld_commit), .ld_abort(ld_abort), .busy(busy_a), .mem_we(we_a),
        .mem_addr(addr_a), .mem_wdata(wd_a)
    );

    pgwr_buffer #(
        .PAGE_BYTES(8), .BUSY_CYCLES(3), .SERIAL_PROG(1'b1), .STRICT_ABORT(1'b1)
    ) u_pgwr_buffer_b (
        .clk(clk), .rst_n(rst_n), .ld_start(ld_start), .ld_addr(ld_addr),
        .byte_stb(byte_stb), .byte_data(byte_data), .byte_partial(byte_partial),
        .ld_commit(ld_commit), .ld_abort(ld_abort), .busy(busy_b), .mem_we(we_b),
        .mem_addr(addr_b), .mem_wdata(wd_b)
    );

    int pg_sz [2] = '{16, 8};
    int bcyc  [2] = '{20, 3};
    bit ser   [2] = '{1'b0, 1'b1};
    bit strict[2] = '{1'b0, 1'b1};

    int errors = 0;
    int checks = 0;
    bit done_flag = 1'b0;
    bit frozen = 1'b0;
    int stray = 0;

    logic [7:0] sh_mem  [2][256];
    logic [7:0] exp_mem [2][256];
    bit         m_open [2];
    int         m_page [2];
    int         m_off  [2];
    bit         m_val  [2][16];
    logic [7:0] m_dat  [2][16];
    int exp_len [2];
    int exp_wr  [2];
    int mon_bc  [2];
    int mon_wr  [2];
    int mon_bad [2];
    logic [7:0] data_seq = 8'h11;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    // Record array writes and their position inside each busy period.
    always @(negedge clk) begin
        if (rst_n) begin
            for (int u = 0; u < 2; u++) begin
                logic b, w;
                logic [7:0] a, d;
                b = u ? busy_b : busy_a;
                w = u ? we_b : we_a;
                a = u ? addr_b : addr_a;
                d = u ? wd_b : wd_a;
                if (b) begin
                    if (w) begin
                        sh_mem[u][a] = d;
                        if (mon_bc[u] != (ser[u] ? mon_wr[u] * bcyc[u] : mon_wr[u]))
                            mon_bad[u]++;
                        mon_wr[u]++;
                    end
                    mon_bc[u]++;
                end else if (w) begin
                    stray++;
                end
            end
        end
    end

    task automatic do_start(input logic [7:0] a);
        ld_start = 1'b1;
        ld_addr = a;
        tick();
        ld_start = 1'b0;
        if (!frozen)
            for (int u = 0; u < 2; u++) begin
                m_open[u] = 1'b1;
                m_page[u] = a / pg_sz[u];
                m_off[u] = a % pg_sz[u];
                for (int o = 0; o < 16; o++) m_val[u][o] = 1'b0;
            end
    endtask

    task automatic do_byte;
        data_seq = data_seq * 8'd5 + 8'd23;
        byte_stb = 1'b1;
        byte_data = data_seq;
        tick();
        byte_stb = 1'b0;
        if (!frozen)
            for (int u = 0; u < 2; u++)
                if (m_open[u]) begin
                    m_val[u][m_off[u]] = 1'b1;
                    m_dat[u][m_off[u]] = data_seq;
                    m_off[u] = (m_off[u] + 1) % pg_sz[u];
                end
    endtask

    task automatic do_commit(input bit partial);
        ld_commit = 1'b1;
        byte_partial = partial;
        tick();
        ld_commit = 1'b0;
        byte_partial = 1'b0;
        if (!frozen)
            for (int u = 0; u < 2; u++)
                if (m_open[u]) begin
                    if (!(partial && strict[u])) begin
                        int n;
                        n = 0;
                        for (int o = 0; o < pg_sz[u]; o++)
                            if (m_val[u][o]) begin
                                exp_mem[u][m_page[u] * pg_sz[u] + o] = m_dat[u][o];
                                n++;
                            end
                        exp_wr[u] = n;
                        exp_len[u] = (n == 0) ? 0 : (ser[u] ? n * bcyc[u] : bcyc[u]);
                    end
                    m_open[u] = 1'b0;
                    for (int o = 0; o < 16; o++) m_val[u][o] = 1'b0;
                end
    endtask

    task automatic do_abort;
        ld_abort = 1'b1;
        tick();
        ld_abort = 1'b0;
        if (!frozen)
            for (int u = 0; u < 2; u++) begin
                m_open[u] = 1'b0;
                for (int o = 0; o < 16; o++) m_val[u][o] = 1'b0;
            end
    endtask

    // Wait until both instances are idle, then compare length, writes and array image.
    task automatic finish_txn(input string tag);
        int guard;
        guard = 0;
        while ((busy_a || busy_b) && guard < 400) begin
            tick();
            guard++;
        end
        tick();
        for (int u = 0; u < 2; u++) begin
            int mism;
            mism = 0;
            for (int i = 0; i < 256; i++)
                if (sh_mem[u][i] !== exp_mem[u][i]) mism++;
            chk(mon_bc[u] == exp_len[u], u ? "R8 busy length" : "R7 busy length",
                mon_bc[u], exp_len[u]);
            chk(mon_wr[u] == exp_wr[u], "R4 write count", mon_wr[u], exp_wr[u]);
            chk(mon_bad[u] == 0, u ? "R8 write timing" : "R7 write timing", mon_bad[u], 0);
            chk(mism == 0, tag, mism, 0);
            mon_bc[u] = 0;
            mon_wr[u] = 0;
            mon_bad[u] = 0;
            exp_len[u] = 0;
            exp_wr[u] = 0;
        end
    endtask

    initial begin
        int lens [5] = '{1, 3, 8, 16, 17};
        for (int u = 0; u < 2; u++) begin
            for (int i = 0; i < 256; i++) begin
                sh_mem[u][i] = 8'h00;
                exp_mem[u][i] = 8'h00;
            end
            m_open[u] = 1'b0;
            exp_len[u] = 0;
            exp_wr[u] = 0;
            mon_bc[u] = 0;
            mon_wr[u] = 0;
            mon_bad[u] = 0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_a && !busy_b, "R1 busy after reset", busy_a + busy_b, 0);
        chk(!we_a && !we_b, "R1 write enable after reset", we_a + we_b, 0);
        tick();

        // Sweep every start offset against several load lengths (R2, R3, R5, R6).
        for (int s = 0; s < 16; s++) begin
            for (int ni = 0; ni < 5; ni++) begin
                logic [7:0] a;
                bit part;
                a = 8'(((s * 53 + ni * 97) & 8'hF0) | s);
                part = (ni == 1) && (s % 2 == 0);
                do_start(a);
                for (int k = 0; k < lens[ni]; k++) do_byte();
                do_commit(part);
                if (part)
                    finish_txn("R5 R6 mid-byte commit");
                else if (lens[ni] > 8)
                    finish_txn("R3 wrapped load image");
                else
                    finish_txn("R2 array image");
            end
        end

        // R9: abort, and commit with nothing loaded.
        do_start(8'h47);
        repeat (4) do_byte();
        do_abort();
        finish_txn("R9 abort writes nothing");
        do_start(8'h90);
        do_commit(1'b0);
        finish_txn("R9 empty commit");

        // R10: stimulus while busy is ignored; the closed load stays closed.
        do_start(8'h3C);
        repeat (2) do_byte();
        do_commit(1'b0);
        frozen = 1'b1;
        do_start(8'hC5);
        do_byte();
        do_commit(1'b0);
        do_abort();
        frozen = 1'b0;
        finish_txn("R10 ignored while busy");
        do_byte();
        do_commit(1'b0);
        finish_txn("R10 no load opened while busy");

        // R11: a stray byte, then a restart that drops earlier loaded bytes.
        do_byte();
        do_start(8'h61);
        repeat (3) do_byte();
        do_start(8'h65);
        do_byte();
        do_commit(1'b0);
        finish_txn("R11 restart clears flags");

        chk(stray == 0, "R12 writes outside busy", stray, 0);

        if (!done_flag) begin
            done_flag = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule